// File: doc/BRIEF.md
# Hybrid Priority Bus Arbiter with Latency Panic Override

This block decides which of `N_MST` masters owns a shared bus. In ordinary traffic it grants the requesting master with the largest programmable priority value, and equal values go to the lower master number. Each master also has a wait allowance, a latency timer and an enable bit for that timer. When an enabled timer runs out while its master is still waiting, the master enters a panic state. While any requesting master is in panic, only panic masters can win. Among them the priority value decides again, and ties again go to the lower number.

A grant stays in force until the current owner pulses `bus_release`. A new decision is made only on such a pulse or when the bus is idle, so a transfer in progress is never cut off. Software-side setup goes through a single write port. The port selects a master and one of its fields, and the write takes effect at the next clock edge.

Top module: `hpa_arbiter`

## Requirements
- R1: After synchronous reset, `grant` is 0, `grant_idx` is 0, `grant_valid` is 0 and `panic` is 0. Every priority resets to 0, every wait allowance to all ones, and every timer enable to 0.
- R2: On an arbitration edge with no requesting master in panic, the registered grant goes to the requester with the largest priority value. Equal values go to the lower index. The grant is visible after that edge.
- R3: An arbitration edge is a clock edge where `grant_valid` is 0 or `bus_release` is 1. On any other edge, `grant`, `grant_idx` and `grant_valid` keep their values, whatever the requests or priorities do.
- R4: `grant` is zero or one-hot. When `grant_valid` is 1, `grant[grant_idx]` is 1. When it is 0, `grant` is 0.
- R5: A master is waiting when it requests and is not the current owner. On the first waiting edge its timer loads the allowance. On each further waiting edge the timer drops by one, and it stops at 0. `panic[i]` is 1 when the timer enable is set, the master is waiting and the timer is 0. With allowance M, panic shows M+1 edges after waiting begins.
- R6: A master whose timer enable is 0 never shows panic, even with the timer at 0.
- R7: On an arbitration edge where one or more requesting masters show panic, only those masters can win. Among them the largest priority wins, and ties go to the lower index.
- R8: Winning a grant clears the master's waiting state and its panic. The master's next wait reloads the timer from the allowance.
- R9: A write with `cfg_we`=1 selects master `cfg_sel` and field `cfg_field`. Field code 0 is priority (low `PRIO_W` bits of `cfg_data`), 1 is wait allowance, and 2 is timer enable (bit 0). Code 3 changes nothing.
- R10: An arbitration edge with no requests leaves `grant_valid` 0 and `grant` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MST | Request line per master |
| bus_release | input | 1 | Single-cycle pulse ending the current ownership |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IDX_W | Master selected by the write |
| cfg_field | input | 2 | Field code (0 priority, 1 allowance, 2 enable, 3 none) |
| cfg_data | input | LAT_W | Write data (LAT_W >= PRIO_W) |
| grant | output | N_MST | Registered one-hot grant |
| grant_idx | output | IDX_W | Index of the granted master |
| grant_valid | output | 1 | Bus owned |
| panic | output | N_MST | Per-master panic status |

## Verification
Several properties are checked on every cycle. The grant must be one-hot and match its index. It must not change outside an arbitration edge, and it must go only to a master that was requesting. The bus must fall idle after a release with no requests. A panic requester must beat any other requester. A panic bit may rise only for a master that was requesting, and it must clear on the master's grant. The exact count of edges before panic, the effect of a clear enable, the reload after a grant, priority ordering and ties, and the reserved field code can only be shown by the bench's directed scenarios. A cycle-level reference model covers the random traffic.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  typedef enum logic [1:0] {
    FLD_PRIO   = 2'd0,
    FLD_ALLOW  = 2'd1,
    FLD_ENABLE = 2'd2,
    FLD_NONE   = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/hpa_cfg_bank.sv
module hpa_cfg_bank #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3,
  parameter int LAT_W  = 8,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [IDX_W-1:0]             sel,
  input  logic [1:0]                   field,
  input  logic [LAT_W-1:0]             data,
  output logic [N_MST-1:0][PRIO_W-1:0] prio_o,
  output logic [N_MST-1:0][LAT_W-1:0]  allow_o,
  output logic [N_MST-1:0]             en_o
);
  import hpa_pkg::*;

  cfg_field_e fld;
  assign fld = cfg_field_e'(field);

  for (genvar g = 0; g < N_MST; g++) begin : g_slot
    logic hit;
    assign hit = we && (sel == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        prio_o[g]  <= '0;
        allow_o[g] <= '1;
        en_o[g]    <= 1'b0;
      end else if (hit) begin
        case (fld)
          FLD_PRIO:   prio_o[g]  <= data[PRIO_W-1:0];
          FLD_ALLOW:  allow_o[g] <= data;
          FLD_ENABLE: en_o[g]    <= data[0];
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hpa_wait_timer.sv
module hpa_wait_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             owner,
  input  logic             won,
  input  logic             en,
  input  logic [LAT_W-1:0] allow,
  output logic             panic
);
  logic             waiting;
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      cnt     <= '0;
    end else if (!req || owner || won) begin
      waiting <= 1'b0;
    end else if (!waiting) begin
      waiting <= 1'b1;
      cnt     <= allow;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign panic = en && waiting && (cnt == '0);
endmodule

// File: rtl/hpa_select.sv
module hpa_select #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0]             cand,
  input  logic [N_MST-1:0][PRIO_W-1:0] prio,
  output logic                         found,
  output logic [IDX_W-1:0]             win_idx,
  output logic [N_MST-1:0]             win_oh
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio[i] >= best)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        best    = prio[i];
      end
    end
  end

  always_comb begin
    win_oh = '0;
    if (found) win_oh[win_idx] = 1'b1;
  end
endmodule

// File: rtl/hpa_arbiter.sv
module hpa_arbiter #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3,
  parameter int LAT_W  = 8,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] req,
  input  logic             bus_release,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_sel,
  input  logic [1:0]       cfg_field,
  input  logic [LAT_W-1:0] cfg_data,
  output logic [N_MST-1:0] grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_valid,
  output logic [N_MST-1:0] panic
);
  logic [N_MST-1:0][PRIO_W-1:0] prio;
  logic [N_MST-1:0][LAT_W-1:0]  allow;
  logic [N_MST-1:0]             en;
  logic [N_MST-1:0]             panic_st;
  logic [N_MST-1:0]             panic_live;
  logic [N_MST-1:0]             cand;
  logic [N_MST-1:0]             win_oh;
  logic [IDX_W-1:0]             win_idx;
  logic                         found;
  logic                         arb;

  hpa_cfg_bank #(.N_MST(N_MST), .PRIO_W(PRIO_W), .LAT_W(LAT_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .field(cfg_field),
    .data(cfg_data), .prio_o(prio), .allow_o(allow), .en_o(en)
  );

  assign arb = !grant_valid || bus_release;

  for (genvar g = 0; g < N_MST; g++) begin : g_tmr
    hpa_wait_timer #(.LAT_W(LAT_W)) u_tmr (
      .clk(clk), .rst(rst), .req(req[g]), .owner(grant[g]),
      .won(arb && win_oh[g]), .en(en[g]), .allow(allow[g]),
      .panic(panic_st[g])
    );
  end

  assign panic_live = panic_st & req;
  assign cand       = (|panic_live) ? panic_live : req;

  hpa_select #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_sel (
    .cand(cand), .prio(prio), .found(found), .win_idx(win_idx), .win_oh(win_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      grant_idx   <= '0;
      grant_valid <= 1'b0;
    end else if (arb) begin
      grant       <= win_oh;
      grant_idx   <= found ? win_idx : '0;
      grant_valid <= found;
    end
  end

  assign panic = panic_st;
endmodule

// File: rtl/hpa_arbiter_chk.sv
module hpa_arbiter_chk #(
  parameter int N_MST  = 4,
  parameter int IDX_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [N_MST-1:0] req,
  input logic             bus_release,
  input logic [N_MST-1:0] grant,
  input logic [IDX_W-1:0] grant_idx,
  input logic             grant_valid,
  input logic [N_MST-1:0] panic
);
  logic arb_edge;
  assign arb_edge = !grant_valid || bus_release;

  AST_ONEHOT_GNT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R4
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> grant[grant_idx]); // R4
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !bus_release) |=> (grant_valid && $stable(grant))); // R3
  AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    arb_edge |=> ((grant & ~$past(req)) == '0)); // R2
  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (rst)
    (arb_edge && req == '0) |=> !grant_valid); // R10
  AST_PANIC_FIRST: assert property (@(posedge clk) disable iff (rst)
    (arb_edge && (req & panic) != '0) |=> ((grant & $past(req & panic)) != '0)); // R7

  for (genvar g = 0; g < N_MST; g++) begin : g_m
    AST_PANIC_REQ: assert property (@(posedge clk) disable iff (rst)
      $rose(panic[g]) |-> $past(req[g])); // R5
    AST_GNT_CLR: assert property (@(posedge clk) disable iff (rst)
      $rose(grant[g]) |-> !panic[g]); // R8
  end
endmodule

bind hpa_arbiter hpa_arbiter_chk #(.N_MST(N_MST), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .bus_release(bus_release), .grant(grant),
  .grant_idx(grant_idx), .grant_valid(grant_valid), .panic(panic)
);

// File: tb/tb_hpa_arbiter.sv
module tb_hpa_arbiter;
  localparam int N = 4;
  localparam int PW = 3;
  localparam int LW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0;
  logic rel = 1'b0;
  logic we = 1'b0;
  logic [IW-1:0] sel = '0;
  logic [1:0] fld = '0;
  logic [LW-1:0] dat = '0;
  logic [N-1:0] grant;
  logic [IW-1:0] grant_idx;
  logic grant_valid;
  logic [N-1:0] panic;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hpa_arbiter dut (
    .clk(clk), .rst(rst), .req(req), .bus_release(rel), .cfg_we(we),
    .cfg_sel(sel), .cfg_field(fld), .cfg_data(dat), .grant(grant),
    .grant_idx(grant_idx), .grant_valid(grant_valid), .panic(panic)
  );

  // reference model state
  logic [PW-1:0] m_prio [N];
  logic [LW-1:0] m_allow [N];
  logic          m_en [N];
  logic          m_wait [N];
  logic [LW-1:0] m_cnt [N];
  logic [N-1:0]  m_gnt;
  logic [IW-1:0] m_idx;
  logic          m_vld;

  function automatic logic [N-1:0] m_panic();
    logic [N-1:0] p = '0;
    for (int i = 0; i < N; i++) p[i] = m_en[i] && m_wait[i] && (m_cnt[i] == '0);
    return p;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_prio[i] = '0; m_allow[i] = '1; m_en[i] = 1'b0;
      m_wait[i] = 1'b0; m_cnt[i] = '0;
    end
    m_gnt = '0; m_idx = '0; m_vld = 1'b0;
  endtask

  task automatic model_step();
    logic [N-1:0] pl, cand, win;
    logic found, arb;
    int w, best;
    pl = m_panic() & req;
    cand = (pl != '0) ? pl : req;
    found = 1'b0; w = 0; best = -1;
    for (int i = 0; i < N; i++)
      if (cand[i] && int'(m_prio[i]) > best) begin best = int'(m_prio[i]); w = i; found = 1'b1; end
    win = '0;
    if (found) win[w] = 1'b1;
    arb = !m_vld || rel;
    for (int i = 0; i < N; i++) begin
      if (!req[i] || m_gnt[i] || (arb && win[i])) m_wait[i] = 1'b0;
      else if (!m_wait[i]) begin m_wait[i] = 1'b1; m_cnt[i] = m_allow[i]; end
      else if (m_cnt[i] != '0) m_cnt[i] = m_cnt[i] - 1'b1;
    end
    if (arb) begin m_gnt = win; m_idx = found ? IW'(w) : '0; m_vld = found; end
    if (we) begin
      case (fld)
        2'd0: m_prio[sel] = dat[PW-1:0];
        2'd1: m_allow[sel] = dat;
        2'd2: m_en[sel] = dat[0];
        default: ;
      endcase
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R2 model grant", 32'(grant), 32'(m_gnt));
    chk("R4 model index/valid", {30'(grant_idx), 1'b0, grant_valid}, {30'(m_idx), 1'b0, m_vld});
    chk("R5 model panic", 32'(panic), 32'(m_panic()));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic wr(int s, int f, int d);
    we = 1'b1; sel = IW'(s); fld = 2'(f); dat = LW'(d);
    cyc();
    we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset grant", 32'(grant), 0);
    chk("R1 reset valid", 32'(grant_valid), 0);
    chk("R1 reset idx", 32'(grant_idx), 0);
    chk("R1 reset panic", 32'(panic), 0);

    req = 4'b1010; cyc();
    chk("R2 tie to lower index", 32'(grant), 32'h2);
    wr(2, 0, 5); wr(3, 0, 5); wr(0, 0, 2);
    chk("R3 grant held without release", 32'(grant), 32'h2);
    rel = 1'b1; req = 4'b1101; cyc(); rel = 1'b0;
    chk("R2 highest priority, tie lower", 32'(grant), 32'h4);
    rel = 1'b1; req = 4'b0000; cyc(); rel = 1'b0;
    chk("R10 idle after release", {31'(grant), grant_valid}, 0);

    wr(1, 1, 3); wr(1, 2, 1);
    req = 4'b1000; cyc();
    chk("R2 single requester", 32'(grant), 32'h8);
    req = 4'b1010;
    repeat (3) cyc();
    chk("R5 no panic before allowance", 32'(panic), 0);
    cyc();
    chk("R5 panic after allowance+1", 32'(panic), 32'h2);
    chk("R3 panic does not preempt", 32'(grant), 32'h8);
    rel = 1'b1; req = 4'b1110; cyc(); rel = 1'b0;
    chk("R7 panic overrides priority", 32'(grant), 32'h2);
    chk("R8 grant clears panic", 32'(panic), 0);

    req = 4'b0011;
    wr(0, 1, 0);
    repeat (4) cyc();
    chk("R6 disabled timer never panics", 32'(panic[0]), 0);

    rel = 1'b1; cyc(); rel = 1'b0;
    chk("R2 m0 wins by priority", 32'(grant), 32'h1);
    repeat (3) cyc();
    chk("R8 reload delays panic", 32'(panic), 0);
    cyc();
    chk("R8 panic after reload", 32'(panic), 32'h2);

    wr(0, 3, 7);
    rel = 1'b1; req = 4'b0101; cyc(); rel = 1'b0;
    chk("R9 reserved field ignored", 32'(grant), 32'h4);
    chk("R4 index matches grant", 32'(grant_idx), 2);

    for (int k = 0; k < 4000; k++) begin
      req = N'($urandom);
      rel = ($urandom % 4) == 0;
      we = ($urandom % 8) == 0;
      sel = IW'($urandom);
      fld = 2'($urandom);
      dat = (fld == 2'd1) ? LW'($urandom % 8) : LW'($urandom);
      cyc();
      chk("R4 grant one-hot", 32'($countones(grant) <= 1), 1);
    end
    we = 1'b0; rel = 1'b0; req = '0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule